// File: doc/BRIEF.md
# Self-Timed EEPROM Byte Write Controller

This block sits on the host side of an external parallel EEPROM whose byte writes time themselves. It takes one write request at a time over a valid/ready handshake. Each request carries an 11-bit address and a data byte. The block then drives the memory's chip-select, read-strobe and write-strobe lines in a fixed order, with set-up, pulse and hold intervals counted in clock cycles.

Once the write strobe ends, the block waits for the memory's internal programming to finish. It detects the end in one of two ways, chosen by a mode input:

- **Data polling:** it reads the same address again and again until the top data bit matches the value written. While programming is in progress that bit reads back inverted.
- **Busy line:** it watches an open-drain ready/busy input, which is low while programming is in progress.

A deadline counter starts when the write strobe rises. If the deadline expires before completion is seen, the operation is abandoned. Every operation ends with a one-cycle pulse on either the done output or the timeout output.

After reset the block holds off for a power-on interval before it accepts its first request. Every interval is a parameter. At the 250 MHz default clock, the defaults give a 5 ms power-on hold, a 1 ms deadline and a 200 ns read access time.

Top module: `nvm_byte_writer`

## Requirements
- R1: After reset, `req_ready` stays low and all three strobes stay high (inactive) for exactly `PWR_ON_CYC` clock cycles. `req_ready` is high in the next cycle.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the next cycle through the cycle in which `done` or `timeout` is high, and is high again in the cycle after that.
- R3: `mem_ce_n` is low, with address and data driven, for `SETUP_CYC` cycles before `mem_we_n` falls. `mem_we_n` then stays low for exactly `PULSE_CYC` cycles. `mem_oe_n` is high whenever `mem_we_n` is low.
- R4: Address and write data stay stable while `mem_we_n` is low. `mem_dq_oe` is still high and `mem_ce_n` still low in the cycle in which `mem_we_n` returns high.
- R5: With `use_busy` = 0, the block polls the memory. Each poll read drives `mem_ce_n` = 0, `mem_oe_n` = 0 and `mem_we_n` = 1 for `ACCESS_CYC` cycles, then samples data bit 7 (`POLL_BIT`). It reports done only when that bit equals bit 7 of the written byte, and never while the memory's internal write is still running.
- R6: With `use_busy` = 1, the block ignores `mem_ready` for `BUSY_LAT_CYC` cycles after the hold interval. It then reports done once the synchronized `mem_ready` is high (1 = ready, 0 = busy).
- R7: If completion is not seen within about `TIMEOUT_CYC` cycles of the rising edge of `mem_we_n`, `timeout` pulses for one cycle and `done` stays low.
- R8: `done` and `timeout` are each high for exactly one cycle per operation and are never high together.
- R9: `mem_dq_oe` is low while powering up, while idle and during every poll read. It is high only while `mem_ce_n` is low and `mem_oe_n` is high.
- R10: In busy-line mode `mem_oe_n` stays high for the whole operation.
- R11: The written byte reaches the addressed location, including the lowest (0) and highest (2047) addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | ADDR_W | Byte address of the request |
| req_data | input | DATA_W | Byte to write |
| use_busy | input | 1 | 1 = wait on ready/busy line, 0 = data polling |
| done | output | 1 | One-cycle pulse: write completed |
| timeout | output | 1 | One-cycle pulse: deadline expired |
| mem_addr | output | ADDR_W | Address to the memory |
| mem_dq_o | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the data bus driver |
| mem_dq_i | input | DATA_W | Data read from the memory bus |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_ready | input | 1 | Ready/busy line, low while programming |

## Verification
The assertions take three things for granted:

- The host keeps `use_busy` unchanged from acceptance until the result pulse.
- The memory pulls `mem_ready` low within `BUSY_LAT_CYC` cycles of the write strobe rising.
- During programming, a read of the address being written returns its top bit inverted.

The bench's memory model meets these: it goes busy one cycle after it sees the rising strobe, and it inverts the polled bit until its write completes. Each request in the bench is issued with a fixed mode, and the next request waits until the model is idle again.

// File: rtl/nvm_wr_pkg.sv
package nvm_wr_pkg;

   typedef enum logic [3:0] {
      S_PWR,
      S_IDLE,
      S_SETUP,
      S_PULSE,
      S_HOLD,
      S_READ,
      S_GAP,
      S_SETTLE,
      S_WAITRDY,
      S_REPORT
   } wr_state_e;

   // bits needed to hold values 0..n
   function automatic int unsigned cnt_bits(input longint unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

   function automatic longint unsigned max2(input longint unsigned a, input longint unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/nvm_cycle_cnt.sv
module nvm_cycle_cnt #(
   parameter int unsigned   W       = 8,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= RST_VAL;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/nvm_done_detect.sv
module nvm_done_detect #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned POLL_BIT    = 7,
   parameter bit          HAS_RDY_PIN = 1'b1,
   parameter int unsigned RDY_SYNC    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              use_busy,
   input  logic              mem_ready,
   input  logic [DATA_W-1:0] rd_data,
   input  logic [DATA_W-1:0] exp_data,
   output logic              busy_sel,
   output logic              rdy_seen,
   output logic              poll_match
);
   assign poll_match = (rd_data[POLL_BIT] == exp_data[POLL_BIT]);

   logic unused_bits;
   assign unused_bits = ^{rd_data, exp_data};

   if (HAS_RDY_PIN) begin : g_rdy
      logic [RDY_SYNC-1:0] sync_q;
      always_ff @(posedge clk) begin
         if (!rst_n) sync_q[0] <= 1'b0;
         else        sync_q[0] <= mem_ready;
      end
      for (genvar i = 1; i < RDY_SYNC; i++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q[i] <= 1'b0;
            else        sync_q[i] <= sync_q[i-1];
         end
      end
      assign busy_sel = use_busy;
      assign rdy_seen = sync_q[RDY_SYNC-1];
   end else begin : g_nordy
      logic unused_rdy;
      assign unused_rdy = ^{use_busy, mem_ready, clk, rst_n};
      assign busy_sel   = 1'b0;
      assign rdy_seen   = 1'b0;
   end
endmodule

// File: rtl/nvm_byte_writer.sv
module nvm_byte_writer
   import nvm_wr_pkg::*;
#(
   parameter int unsigned ADDR_W       = 11,
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned POLL_BIT     = DATA_W - 1,
   parameter int unsigned PWR_ON_CYC   = 1_250_000,
   parameter int unsigned TIMEOUT_CYC  = 250_000,
   parameter int unsigned SETUP_CYC    = 2,
   parameter int unsigned PULSE_CYC    = 25,
   parameter int unsigned HOLD_CYC     = 3,
   parameter int unsigned ACCESS_CYC   = 50,
   parameter int unsigned BUSY_LAT_CYC = 8,
   parameter bit          HAS_RDY_PIN  = 1'b1,
   parameter int unsigned RDY_SYNC     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   input  logic              use_busy,
   output logic              done,
   output logic              timeout,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_i,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   input  logic              mem_ready
);
   localparam longint unsigned PH_MAX =
      max2(max2(max2(PWR_ON_CYC, ACCESS_CYC), max2(PULSE_CYC, SETUP_CYC)),
           max2(HOLD_CYC, BUSY_LAT_CYC));
   localparam int unsigned PH_W = cnt_bits(PH_MAX);
   localparam int unsigned DL_W = cnt_bits(TIMEOUT_CYC);

   // elaboration-time parameter checks
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("nvm_byte_writer: widths must be at least 1");
   end
   if (POLL_BIT >= DATA_W) begin : g_bad_poll
      $error("nvm_byte_writer: POLL_BIT outside data word");
   end
   if (PWR_ON_CYC < 1 || TIMEOUT_CYC < 1 || SETUP_CYC < 1 || PULSE_CYC < 1 ||
       HOLD_CYC < 1 || ACCESS_CYC < 1 || BUSY_LAT_CYC < 1) begin : g_bad_time
      $error("nvm_byte_writer: every interval must be at least one cycle");
   end
   if (HAS_RDY_PIN && RDY_SYNC < 1) begin : g_bad_sync
      $error("nvm_byte_writer: RDY_SYNC must be at least 1");
   end

   wr_state_e         st_q, st_d;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              done_q, to_q;
   logic              fin_ok, fin_to;
   logic              ph_load, ph_zero;
   logic [PH_W-1:0]   ph_val;
   logic              dl_load, dl_zero;
   logic              busy_sel, rdy_seen, poll_match;
   logic              accept;

   nvm_cycle_cnt #(.W(PH_W), .RST_VAL(PH_W'(PWR_ON_CYC - 1))) i_phase (
      .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .zero(ph_zero)
   );

   nvm_cycle_cnt #(.W(DL_W), .RST_VAL('0)) i_deadline (
      .clk(clk), .rst_n(rst_n), .load(dl_load),
      .load_val(DL_W'(TIMEOUT_CYC - 1)), .zero(dl_zero)
   );

   nvm_done_detect #(
      .DATA_W(DATA_W), .POLL_BIT(POLL_BIT),
      .HAS_RDY_PIN(HAS_RDY_PIN), .RDY_SYNC(RDY_SYNC)
   ) i_detect (
      .clk(clk), .rst_n(rst_n), .use_busy(use_busy), .mem_ready(mem_ready),
      .rd_data(mem_dq_i), .exp_data(data_q),
      .busy_sel(busy_sel), .rdy_seen(rdy_seen), .poll_match(poll_match)
   );

   assign accept = req_valid && (st_q == S_IDLE);

   always_comb begin
      st_d    = st_q;
      ph_load = 1'b0;
      ph_val  = '0;
      dl_load = 1'b0;
      fin_ok  = 1'b0;
      fin_to  = 1'b0;
      unique case (st_q)
         S_PWR: begin
            if (ph_zero) st_d = S_IDLE;
         end
         S_IDLE: begin
            if (req_valid) begin
               st_d    = S_SETUP;
               ph_load = 1'b1;
               ph_val  = PH_W'(SETUP_CYC - 1);
            end
         end
         S_SETUP: begin
            if (ph_zero) begin
               st_d    = S_PULSE;
               ph_load = 1'b1;
               ph_val  = PH_W'(PULSE_CYC - 1);
            end
         end
         S_PULSE: begin
            if (ph_zero) begin
               st_d    = S_HOLD;
               ph_load = 1'b1;
               ph_val  = PH_W'(HOLD_CYC - 1);
               dl_load = 1'b1;
            end
         end
         S_HOLD: begin
            if (dl_zero) begin
               fin_to = 1'b1;
            end else if (ph_zero) begin
               ph_load = 1'b1;
               if (busy_sel) begin
                  st_d   = S_SETTLE;
                  ph_val = PH_W'(BUSY_LAT_CYC - 1);
               end else begin
                  st_d   = S_READ;
                  ph_val = PH_W'(ACCESS_CYC - 1);
               end
            end
         end
         S_READ: begin
            if (ph_zero && poll_match) fin_ok = 1'b1;
            else if (dl_zero)          fin_to = 1'b1;
            else if (ph_zero)          st_d   = S_GAP;
         end
         S_GAP: begin
            if (dl_zero) begin
               fin_to = 1'b1;
            end else begin
               st_d    = S_READ;
               ph_load = 1'b1;
               ph_val  = PH_W'(ACCESS_CYC - 1);
            end
         end
         S_SETTLE: begin
            if (dl_zero)      fin_to = 1'b1;
            else if (ph_zero) st_d   = S_WAITRDY;
         end
         S_WAITRDY: begin
            if (rdy_seen)     fin_ok = 1'b1;
            else if (dl_zero) fin_to = 1'b1;
         end
         S_REPORT: begin
            st_d = S_IDLE;
         end
         default: st_d = S_IDLE;
      endcase
      if (fin_ok || fin_to) st_d = S_REPORT;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= S_PWR;
         addr_q <= '0;
         data_q <= '0;
         done_q <= 1'b0;
         to_q   <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_q <= fin_ok;
         to_q   <= fin_to;
         if (accept) begin
            addr_q <= req_addr;
            data_q <= req_data;
         end
      end
   end

   assign req_ready = (st_q == S_IDLE);
   assign done      = done_q;
   assign timeout   = to_q;
   assign mem_addr  = addr_q;
   assign mem_dq_o  = data_q;
   assign mem_dq_oe = (st_q == S_SETUP) || (st_q == S_PULSE) || (st_q == S_HOLD);
   assign mem_ce_n  = !((st_q == S_SETUP) || (st_q == S_PULSE) ||
                        (st_q == S_HOLD)  || (st_q == S_READ));
   assign mem_we_n  = (st_q != S_PULSE);
   assign mem_oe_n  = (st_q != S_READ);
endmodule

// File: rtl/nvm_byte_writer_chk.sv
module nvm_byte_writer_chk #(
   parameter int unsigned ADDR_W = 11,
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              done,
   input logic              timeout,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_dq_o,
   input logic              mem_dq_oe,
   input logic              mem_ce_n,
   input logic              mem_oe_n,
   input logic              mem_we_n
);
   // R3
   oe_high_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (mem_oe_n && !mem_ce_n));

   // R4
   write_bus_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |=> ($stable(mem_addr) && $stable(mem_dq_o)));

   // R4
   data_held_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n));

   // R9
   bus_released_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> !mem_dq_oe);

   // R9
   drive_only_when_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (!mem_ce_n && mem_oe_n));

   // R2
   accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R2
   result_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done || timeout) |-> !req_ready);

   // R8
   result_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && timeout));

   // R8
   result_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done || timeout) |=> (!done && !timeout && req_ready));
endmodule

bind nvm_byte_writer nvm_byte_writer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_nvm_byte_writer.sv
`timescale 1ns/1ps
module test_nvm_byte_writer;
   localparam int AW = 11, DW = 8;
   localparam int PWR = 20, TMO = 60, SU = 2, PW = 3, HLD = 2, ACC = 3, BLAT = 4;

   logic clk = 0, rst_n = 0;
   logic req_valid = 0, use_busy = 0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_data = '0;
   logic req_ready, done, timeout, mem_dq_oe, mem_ce_n, mem_oe_n, mem_we_n, mem_ready;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_dq_o, mem_dq_i;

   int n_cmp = 0, n_bad = 0;
   int wr_delay = 6;

   always #2 clk = ~clk;

   nvm_byte_writer #(
      .ADDR_W(AW), .DATA_W(DW), .PWR_ON_CYC(PWR), .TIMEOUT_CYC(TMO),
      .SETUP_CYC(SU), .PULSE_CYC(PW), .HOLD_CYC(HLD), .ACCESS_CYC(ACC),
      .BUSY_LAT_CYC(BLAT), .HAS_RDY_PIN(1'b1), .RDY_SYNC(2)
   ) i_nvm_byte_writer (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_data(req_data), .use_busy(use_busy),
      .done(done), .timeout(timeout), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
      .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i), .mem_ce_n(mem_ce_n),
      .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_ready(mem_ready)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // ---------------- memory model ----------------
   logic [DW-1:0] mem_model [2048];
   int            busy_cnt = 0;
   logic [AW-1:0] pend_addr = '0;
   logic [DW-1:0] pend_data = '0;
   logic          prev_we = 1'b1;
   int            we_low_cnt = 0, setup_cnt = 0, oe_low_cnt = 0, since_rise = 0;

   initial for (int i = 0; i < 2048; i++) mem_model[i] = 8'hFF;

   assign mem_ready = (busy_cnt == 0);

   always_comb begin
      mem_dq_i = 8'h5A;
      if (!mem_ce_n && !mem_oe_n) begin
         if (busy_cnt != 0 && mem_addr == pend_addr)
            mem_dq_i = {~pend_data[7], 7'h2B};
         else
            mem_dq_i = mem_model[mem_addr];
      end
   end

   always @(posedge clk) begin
      if (rst_n) begin
         since_rise <= since_rise + 1;
         if (busy_cnt != 0) begin
            if (busy_cnt == 1) mem_model[pend_addr] <= pend_data;
            busy_cnt <= busy_cnt - 1;
         end
         if (!mem_oe_n) oe_low_cnt <= oe_low_cnt + 1;
         if (mem_ce_n)
            setup_cnt <= 0;
         else if (mem_we_n && mem_dq_oe && prev_we && we_low_cnt == 0)
            setup_cnt <= setup_cnt + 1;
         if (!mem_we_n) begin
            if (prev_we) check(setup_cnt == SU, "R3 setup cycles", setup_cnt, SU);
            we_low_cnt <= we_low_cnt + 1;
         end
         if (mem_we_n && !prev_we) begin
            check(we_low_cnt == PW, "R3 write pulse width", we_low_cnt, PW);
            check(mem_dq_oe && !mem_ce_n, "R4 data driven at strobe rise", mem_dq_oe, 1);
            we_low_cnt <= 0;
            pend_addr  <= mem_addr;
            pend_data  <= mem_dq_o;
            busy_cnt   <= wr_delay;
            since_rise <= 0;
         end
         prev_we <= mem_we_n;
      end
   end

   // ---------------- stimulus ----------------
   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input bit mode, input int dly, input bit expect_to);
      int  waited = 0;
      bit  rdy_low_ok = 1;
      bit  busy_at_done = 0;
      int  rise_gap;
      @(negedge clk);
      while (busy_cnt != 0) @(negedge clk);
      wr_delay   = dly;
      oe_low_cnt = 0;
      req_addr   = a;
      req_data   = d;
      use_busy   = mode;
      req_valid  = 1;
      check(req_ready == 1, "R2 ready before request", req_ready, 1);
      @(posedge clk);
      #1 req_valid = 0;
      @(negedge clk);
      while (!done && !timeout && waited < 2000) begin
         if (req_ready) rdy_low_ok = 0;
         @(negedge clk);
         waited++;
      end
      if (req_ready) rdy_low_ok = 0;
      busy_at_done = done && (busy_cnt != 0);
      rise_gap = since_rise;
      check(rdy_low_ok, "R2 ready low during operation", rdy_low_ok, 1);
      if (expect_to) begin
         check(timeout == 1 && done == 0, "R7 timeout reported", timeout, 1);
         check(rise_gap >= TMO - 2 && rise_gap <= TMO + 2, "R7 deadline length", rise_gap, TMO);
      end else begin
         check(done == 1 && timeout == 0, "R8 done reported", done, 1);
         check(!busy_at_done, "R5 R6 done not before write ends", busy_at_done, 0);
      end
      if (mode) check(oe_low_cnt == 0, "R10 no reads in busy mode", oe_low_cnt, 0);
      else      check(oe_low_cnt >= ACC, "R5 poll reads issued", oe_low_cnt, ACC);
      @(negedge clk);
      check(done == 0 && timeout == 0, "R8 result is single cycle", done | timeout, 0);
      check(req_ready == 1, "R2 ready after result", req_ready, 1);
      check(mem_dq_oe == 0, "R9 bus released when idle", mem_dq_oe, 0);
      while (busy_cnt != 0) @(negedge clk);
      @(negedge clk);
      check(mem_model[a] == d, "R11 byte stored", mem_model[a], d);
   endtask

   initial begin : watchdog
      repeat (150_000) @(posedge clk);
      check(0, "watchdog expired", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      int pwr_cnt = 0;
      bit idle_ok = 1;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 power-on hold
      @(negedge clk);
      while (!req_ready && pwr_cnt < 1000) begin
         if (!(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe)) idle_ok = 0;
         pwr_cnt++;
         @(negedge clk);
      end
      check(pwr_cnt + 1 == PWR, "R1 power-on cycles", pwr_cnt + 1, PWR);
      check(idle_ok, "R1 R9 strobes idle during power-on", idle_ok, 1);

      // sweep both modes, data patterns and write durations
      for (int m = 0; m < 2; m++) begin
         for (int k = 0; k < 16; k++) begin
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            int dl;
            a  = AW'((k * 131 + m * 977) % 2048);
            d  = {k[3:0], ~k[3:0]} ^ (m[0] ? 8'h3C : 8'h00);
            dl = (k % 3 == 0) ? 6 : ((k % 3 == 1) ? 25 : 40);
            do_write(a, d, m[0], dl, 0);
         end
      end
      // address boundaries (R11)
      do_write(11'd0,    8'h80, 0, 10, 0);
      do_write(11'd2047, 8'h01, 1, 10, 0);
      do_write(11'd2047, 8'hFE, 0, 12, 0);
      // R7 deadline expiry in both modes
      do_write(11'd300, 8'h99, 0, 150, 1);
      do_write(11'd301, 8'h11, 1, 150, 1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule